// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block sits beside a small CPU core and decides which of five interrupt sources is serviced next. The sources are a non-maskable trap line, one edge-triggered vectored line (level 7.5), two level-triggered vectored lines (levels 6.5 and 5.5) and a general request line whose restart opcode is supplied elsewhere. A global enable flip-flop is set and cleared by strobes from the core's enable and disable instructions. Three individual mask bits, one for each vectored line, gate the vectored lines. A pending flip-flop remembers a rising edge on the 7.5 line.

Software updates the masks, clears the 7.5 pending flag and drives a serial output bit through one 8-bit set-mask write. A combinational read-mask word returns the masks, the enable state, the three pending indications and the serial input pin. When the core signals an instruction boundary (`accept_ok`), the block presents the winning source and its 16-bit vector address. An acknowledge then updates the internal state.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1, the 7.5 pending flag is 0 and `ser_out` is 0. With all inputs low, `rdm_data` reads 8'h07.
- R2: Priority runs from highest to lowest as trap, 7.5, 6.5, 5.5, general request. `irq_src` codes are 0 none, 1 trap, 2 level 7.5, 3 level 6.5, 4 level 5.5, 5 general request.
- R3: `irq_vec` is 16'h0024 for trap, 16'h003C for 7.5, 16'h0034 for 6.5, 16'h002C for 5.5. It is 16'h0000 for the general request and when there is no request.
- R4: In a set-mask write, bits 2, 1 and 0 are the masks for 7.5, 6.5 and 5.5, and a 1 blocks the line. They load only when bit 3 of the write is 1; otherwise they keep their value.
- R5: A set-mask write with bit 4 set clears the 7.5 pending flag. This clear wins over an edge in the same cycle.
- R6: A set-mask write with bit 6 set loads bit 7 into `ser_out`. With bit 6 clear, `ser_out` keeps its value.
- R7: A rising edge on `src_r75` sets the pending flag one cycle later. The flag stays set after the line falls, and the request appears once the 7.5 mask is 0 and the global enable is 1.
- R8: Levels 6.5, 5.5 and the general request are not latched. When the line drops, the request goes away in the same cycle.
- R9: Trap ignores the enable and the masks. It is requested only after a rising edge followed by the line staying high. Dropping the line cancels it. After a trap acknowledge, a new rising edge is needed.
- R10: `rdm_data` holds the masks in bits [2:0] and the global enable in bit 3. Bits 4, 5 and 6 hold the pending state of 5.5, 6.5 and 7.5, and bit 7 holds `ser_in`.
- R11: Acknowledging a maskable source clears the global enable. Acknowledging 7.5 also clears its pending flag. A trap acknowledge leaves the enable unchanged.
- R12: `ei_stb` sets the enable and `di_stb` clears it. Disable wins when both strobes are high. With `accept_ok` low, `irq_req` is 0 and `irq_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_trap | input | 1 | Non-maskable trap line |
| src_r75 | input | 1 | Edge-triggered vectored line 7.5 |
| src_r65 | input | 1 | Level vectored line 6.5 |
| src_r55 | input | 1 | Level vectored line 5.5 |
| src_intr | input | 1 | General level request |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| setm_we | input | 1 | Set-mask write strobe |
| setm_data | input | 8 | Set-mask write word |
| ser_in | input | 1 | Serial input pin |
| accept_ok | input | 1 | Core is at a point where it can take an interrupt |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_req | output | 1 | An interrupt is presented |
| irq_src | output | 3 | Winning source code |
| irq_vec | output | 16 | Vector address of the winner |
| rdm_data | output | 8 | Read-mask status word |
| ser_out | output | 1 | Serial output bit |

## Verification
The hardest situations to reach are the ones where latched state and live levels disagree. One is a 7.5 edge that arrives while the line is masked and is released only after the input has fallen. Another is a trap acknowledged while its line is still high, which must not be taken again. The stimulus reaches the first by pulsing the line under a mask, then unmasking. It reaches the second by holding the trap high across its acknowledge and then cycling it low and high. A vector table first covers the arbitration among the level lines under varied masks.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // source codes; index order in the request vector is priority order
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_INTR = 3'd5
  } irq_src_e;

  localparam int NSRC = 5;
  // set-mask word fields
  localparam int SM_MSK_LO = 0;
  localparam int SM_MSE    = 3;
  localparam int SM_CLR75  = 4;
  localparam int SM_SOE    = 6;
  localparam int SM_SOD    = 7;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic pend
);
  logic lvl_q, pend_q, pend_d, rise;

  assign rise = lvl & ~lvl_q;

  generate
    if (STICKY) begin : g_sticky
      always_comb begin
        if (clr)       pend_d = 1'b0;
        else if (rise) pend_d = 1'b1;
        else           pend_d = pend_q;
      end
    end else begin : g_qualified
      always_comb begin
        if (clr || !lvl) pend_d = 1'b0;
        else if (rise)   pend_d = 1'b1;
        else             pend_d = pend_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int NMSK = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ei_stb,
  input  logic            di_stb,
  input  logic            take_maskable,
  input  logic            msk_load,
  input  logic [NMSK-1:0] msk_new,
  input  logic            sod_load,
  input  logic            sod_new,
  output logic            ie,
  output logic [NMSK-1:0] msk,
  output logic            sod
);
  logic            ie_q, ie_d;
  logic [NMSK-1:0] msk_q, msk_d;
  logic            sod_q, sod_d;

  always_comb begin
    if (di_stb || take_maskable) ie_d = 1'b0;
    else if (ei_stb)             ie_d = 1'b1;
    else                         ie_d = ie_q;
    msk_d = msk_load ? msk_new : msk_q;
    sod_d = sod_load ? sod_new : sod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      msk_q <= '1;
      sod_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      msk_q <= msk_d;
      sod_q <= sod_d;
    end
  end

  assign ie  = ie_q;
  assign msk = msk_q;
  assign sod = sod_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [NSRC-1:0][VEC_W-1:0] VEC_TAB = '0
) (
  input  logic [NSRC-1:0]  req,
  output irq_src_e         win_src,
  output logic [VEC_W-1:0] win_vec
);
  // index 0 is highest priority: scan from lowest so the highest overwrites
  always_comb begin
    win_src = SRC_NONE;
    win_vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_src = irq_src_e'(3'(i + 1));
        win_vec = VEC_TAB[i];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter int          WORD_W   = 8,
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_R75  = 16'h003C,
  parameter logic [15:0] VEC_R65  = 16'h0034,
  parameter logic [15:0] VEC_R55  = 16'h002C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_trap,
  input  logic              src_r75,
  input  logic              src_r65,
  input  logic              src_r55,
  input  logic              src_intr,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              setm_we,
  input  logic [WORD_W-1:0] setm_data,
  input  logic              ser_in,
  input  logic              accept_ok,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [2:0]        irq_src,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [WORD_W-1:0] rdm_data,
  output logic              ser_out
);
  localparam int NMSK = 3;
  localparam logic [NSRC-1:0][VEC_W-1:0] VTAB = {
    VEC_W'(0), VEC_W'(VEC_R55), VEC_W'(VEC_R65), VEC_W'(VEC_R75), VEC_W'(VEC_TRAP)};

  logic            ie, sod, pend75, trap_arm;
  logic [NMSK-1:0] msk;
  logic [NSRC-1:0] req;
  irq_src_e        win_src;
  logic [VEC_W-1:0] win_vec;
  logic            any_req, take, take_maskable, clr75, clr_trap;
  logic [WORD_W-1:0] unused_setm;

  assign unused_setm = setm_data;

  assign any_req       = accept_ok && (win_src != SRC_NONE);
  assign take          = irq_ack && any_req;
  assign take_maskable = take && (win_src != SRC_TRAP);
  assign clr_trap      = take && (win_src == SRC_TRAP);
  assign clr75         = (setm_we && setm_data[SM_CLR75]) || (take && win_src == SRC_R75);

  irq_ctl_regs #(.NMSK(NMSK)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ei_stb(ei_stb), .di_stb(di_stb), .take_maskable(take_maskable),
    .msk_load(setm_we && setm_data[SM_MSE]),
    .msk_new(setm_data[SM_MSK_LO +: NMSK]),
    .sod_load(setm_we && setm_data[SM_SOE]),
    .sod_new(setm_data[SM_SOD]),
    .ie(ie), .msk(msk), .sod(sod)
  );

  irq_edge_latch #(.STICKY(1'b1)) u_r75 (
    .clk(clk), .rst_n(rst_n), .lvl(src_r75), .clr(clr75), .pend(pend75)
  );

  irq_edge_latch #(.STICKY(1'b0)) u_trap (
    .clk(clk), .rst_n(rst_n), .lvl(src_trap), .clr(clr_trap), .pend(trap_arm)
  );

  // request vector in priority order: msk[2]=7.5, msk[1]=6.5, msk[0]=5.5
  assign req[0] = trap_arm && src_trap;
  assign req[1] = ie && !msk[2] && pend75;
  assign req[2] = ie && !msk[1] && src_r65;
  assign req[3] = ie && !msk[0] && src_r55;
  assign req[4] = ie && src_intr;

  irq_prio_sel #(.VEC_W(VEC_W), .VEC_TAB(VTAB)) u_sel (
    .req(req), .win_src(win_src), .win_vec(win_vec)
  );

  assign irq_req  = any_req;
  assign irq_src  = accept_ok ? win_src : SRC_NONE;
  assign irq_vec  = accept_ok ? win_vec : '0;
  assign rdm_data = {ser_in, pend75, src_r65, src_r55, ie, msk};
  assign ser_out  = sod;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_trap,
  input logic        src_r75,
  input logic        src_r65,
  input logic        src_r55,
  input logic        src_intr,
  input logic        ei_stb,
  input logic        di_stb,
  input logic        setm_we,
  input logic [7:0]  setm_data,
  input logic        ser_in,
  input logic        accept_ok,
  input logic        irq_ack,
  input logic        irq_req,
  input logic [2:0]  irq_src,
  input logic [15:0] irq_vec,
  input logic [7:0]  rdm_data,
  input logic        ser_out
);
  // R11
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_src != 3'd1) |=> !rdm_data[3]);

  // R12
  di_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di_stb |=> !rdm_data[3]);

  // R12
  no_req_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ok |-> !irq_req);

  // R5
  clr75_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setm_we && setm_data[4]) |=> !rdm_data[6]);

  // R7
  pend_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdm_data[6]) |-> $past(src_r75));

  // R9
  trap_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_src == 3'd1) |-> src_trap);

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setm_we && !setm_data[3]) |=> $stable(rdm_data[2:0]));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (.*);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic src_trap, src_r75, src_r65, src_r55, src_intr;
  logic ei_stb, di_stb, setm_we, ser_in, accept_ok, irq_ack;
  logic [7:0] setm_data;
  logic irq_req, ser_out;
  logic [2:0] irq_src;
  logic [15:0] irq_vec;
  logic [7:0] rdm_data;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_trap(src_trap), .src_r75(src_r75), .src_r65(src_r65),
    .src_r55(src_r55), .src_intr(src_intr),
    .ei_stb(ei_stb), .di_stb(di_stb),
    .setm_we(setm_we), .setm_data(setm_data), .ser_in(ser_in),
    .accept_ok(accept_ok), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
    .rdm_data(rdm_data), .ser_out(ser_out)
  );

  // fields: [24:22] masks {7.5,6.5,5.5}, [21:19] {r65,r55,intr}, [18:16] src, [15:0] vec
  localparam logic [24:0] TBL [8] = '{
    {3'b000, 3'b111, 3'd3, 16'h0034},
    {3'b000, 3'b011, 3'd4, 16'h002C},
    {3'b000, 3'b001, 3'd5, 16'h0000},
    {3'b010, 3'b110, 3'd4, 16'h002C},
    {3'b011, 3'b111, 3'd5, 16'h0000},
    {3'b001, 3'b010, 3'd0, 16'h0000},
    {3'b000, 3'b000, 3'd0, 16'h0000},
    {3'b100, 3'b100, 3'd3, 16'h0034}
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic samp();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] w);
    setm_we = 1'b1; setm_data = w;
    cyc();
    setm_we = 1'b0; setm_data = 8'h00;
  endtask

  task automatic pulse_ei();
    ei_stb = 1'b1; cyc(); ei_stb = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  task automatic edge75();
    src_r75 = 1'b1; cyc(); src_r75 = 1'b0; cyc();
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {src_trap, src_r75, src_r65, src_r55, src_intr} = '0;
    {ei_stb, di_stb, setm_we, ser_in, irq_ack} = '0;
    accept_ok = 1'b1; setm_data = 8'h00;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    samp();
    chk("R1 rdm", 16'(rdm_data), 16'h0007);
    chk("R1 ser_out", 16'(ser_out), 16'h0);
    chk("R1 req", 16'(irq_req), 16'h0);

    // R12 enable strobe
    cyc(); pulse_ei(); samp();
    chk("R12 ei sets", 16'(rdm_data[3]), 16'h1);

    // R2 R3 table walk over level lines and masks
    for (int i = 0; i < 8; i++) begin
      cyc();
      wr({5'b00001, TBL[i][24:22]});
      {src_r65, src_r55, src_intr} = TBL[i][21:19];
      samp();
      chk("R2 src", 16'(irq_src), 16'(TBL[i][18:16]));
      chk("R3 vec", irq_vec, TBL[i][15:0]);
      chk("R2 req", 16'(irq_req), 16'(TBL[i][18:16] != 3'd0));
    end
    cyc();
    {src_r65, src_r55, src_intr} = '0;

    // R7 edge latched under mask, fires after unmask
    wr(8'b0000_1100);
    edge75();
    samp();
    chk("R7 pend held", 16'(rdm_data[6]), 16'h1);
    chk("R7 masked no req", 16'(irq_req), 16'h0);
    cyc(); wr(8'b0000_1000); samp();
    chk("R7 src", 16'(irq_src), 16'd2);
    chk("R3 vec75", irq_vec, 16'h003C);
    // R11 acknowledge
    cyc(); ack(); samp();
    chk("R11 ie cleared", 16'(rdm_data[3]), 16'h0);
    chk("R11 pend cleared", 16'(rdm_data[6]), 16'h0);
    chk("R11 no req", 16'(irq_req), 16'h0);

    // R5 software clear, R4 gated masks
    cyc(); pulse_ei(); wr(8'b0000_1100); edge75(); samp();
    chk("R5 pend set", 16'(rdm_data[6]), 16'h1);
    cyc(); wr(8'h10); samp();
    chk("R5 pend cleared", 16'(rdm_data[6]), 16'h0);
    chk("R4 masks kept", 16'(rdm_data[2:0]), 16'h4);
    cyc(); wr(8'h03); samp();
    chk("R4 no mse", 16'(rdm_data[2:0]), 16'h4);

    // R6 serial output
    cyc(); wr(8'hC0); samp();
    chk("R6 sod set", 16'(ser_out), 16'h1);
    cyc(); wr(8'h80); samp();
    chk("R6 sod hold", 16'(ser_out), 16'h1);
    cyc(); wr(8'h40); samp();
    chk("R6 sod clr", 16'(ser_out), 16'h0);

    // R8 level not latched
    cyc(); wr(8'h08); src_r65 = 1'b1; samp();
    chk("R8 req", 16'(irq_src), 16'd3);
    cyc(); src_r65 = 1'b0; samp();
    chk("R8 dropped", 16'(irq_req), 16'h0);

    // R10 read word layout
    cyc(); ser_in = 1'b1; src_r55 = 1'b1; samp();
    chk("R10 rdm", 16'(rdm_data), 16'h0098);

    // R12 accept gating and DI priority
    cyc(); accept_ok = 1'b0; samp();
    chk("R12 no req busy", 16'(irq_req), 16'h0);
    chk("R12 src none", 16'(irq_src), 16'h0);
    cyc(); accept_ok = 1'b1; samp();
    chk("R12 req back", 16'(irq_src), 16'd4);
    cyc(); ei_stb = 1'b1; di_stb = 1'b1; cyc(); ei_stb = 1'b0; di_stb = 1'b0; samp();
    chk("R12 di wins", 16'(rdm_data[3]), 16'h0);
    chk("R12 disabled", 16'(irq_req), 16'h0);
    cyc(); src_r55 = 1'b0; ser_in = 1'b0;

    // R9 trap ignores enable and masks
    wr(8'h0F); src_trap = 1'b1; src_r65 = 1'b1; samp();
    chk("R9 no edge yet", 16'(irq_req), 16'h0);
    cyc(); samp();
    chk("R9 trap src", 16'(irq_src), 16'd1);
    chk("R3 trap vec", irq_vec, 16'h0024);
    cyc(); ack(); samp();
    chk("R9 needs new edge", 16'(irq_req), 16'h0);
    cyc(); src_trap = 1'b0; cyc(); src_trap = 1'b1; cyc(); samp();
    chk("R9 retaken", 16'(irq_src), 16'd1);
    cyc(); src_trap = 1'b0; samp();
    chk("R9 cancel on drop", 16'(irq_req), 16'h0);
    cyc(); src_r65 = 1'b0;

    // R2 trap over 7.5; R11 trap ack leaves enable
    pulse_ei(); wr(8'h08); edge75();
    src_trap = 1'b1; cyc(); samp();
    chk("R2 trap over r75", 16'(irq_src), 16'd1);
    cyc(); ack(); samp();
    chk("R11 trap keeps ie", 16'(rdm_data[3]), 16'h1);
    chk("R2 r75 next", 16'(irq_src), 16'd2);
    cyc(); src_trap = 1'b0; cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule